// File: doc/BRIEF.md
# Double-Word Shift and Normalize Unit

This block shifts a 48-bit operand that is held as two 24-bit halves: an upper half and a lower half. It also holds a 24-bit index value. A caller selects a direction, a 3-bit sub-operation code and a 9-bit shift count, then pulses `start`. The unit moves the operand one bit position per clock. When it finishes, it pulses `done` and presents the updated halves and index on its outputs.

Right shifts can be arithmetic, logical or rotate. Left shifts can be arithmetic, rotate, normalize or cycle normalize. A normalize operation stops as soon as the operand's top two bits differ. It then lowers the index by the number of positions it actually moved. Any count above 48 acts as 48. A rotate through the full 48 positions therefore leaves the operand unchanged.

Top module: `dw_shift_norm`

## Requirements
- R1: Any count above 48 gives the same result as a count of exactly 48, for every sub-operation in both directions.
- R2: With `shl`=0, code 0 is an arithmetic right shift that fills from the top with bit 23 of the upper half. Code 5 is a logical right shift that fills with zeros.
- R3: With `shl`=1, code 0 is an arithmetic left shift. On each step, bit 23 of the lower half enters bit 0 of the upper half and a zero enters bit 0 of the lower half. `ovf` goes high and stays high for the rest of the operation if bit 23 of the upper half ever differs from its value at start.
- R4: With `shl`=1, code 2 is normalize. Before each step it stops if bits 23 and 22 of the upper half differ, and it also stops when the count is used up. The index output equals the index input minus the number of steps taken, modulo 2^24. Every sub-operation other than the two normalize codes returns the index unchanged.
- R5: With `shl`=1, code 6 is cycle normalize. It uses the stopping rule of R4, but each step rotates the 48-bit pair left instead of shifting in a zero.
- R6: Code 4 is a rotate of the 48-bit pair: to the right when `shl`=0 and to the left when `shl`=1. A rotate whose effective count is 0 or 48 leaves both halves unchanged.
- R7: A count of 0 leaves both halves and the index unchanged for every legal sub-operation.
- R8: Right codes 1, 2, 3, 6, 7 and left codes 1, 3, 5, 7 are illegal. An illegal code raises `illegal` and `done` together for one cycle, and the outputs then equal the operand and index inputs.
- R9: `done` is high for exactly one cycle. `ovf` is low for every sub-operation except arithmetic left.
- R10: `start` is ignored while an operation is in progress, even if the inputs change.
- R11: After reset, `done`, `illegal` and `ovf` are low and the data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| shl | input | 1 | 1 selects the left class, 0 the right class |
| subop | input | 3 | Sub-operation code |
| count | input | 9 | Requested shift count |
| hi_in | input | 24 | Upper half of the operand |
| lo_in | input | 24 | Lower half of the operand |
| idx_in | input | 24 | Index value |
| hi_out | output | 24 | Upper half of the result |
| lo_out | output | 24 | Lower half of the result |
| idx_out | output | 24 | Index value after the operation |
| done | output | 1 | One-cycle pulse when the results are valid |
| illegal | output | 1 | Pulses with `done` when the code was illegal |
| ovf | output | 1 | Sticky sign-change flag for arithmetic left shift |

## Verification
Two stopping conditions of normalize can occur in the same cycle: the top bits of the upper half become unequal, and the count runs out. The sweep provokes this by pairing operands whose leading bit lies at positions 1, 22, 23 and 24 with counts near and across those positions. For each such case, the bench compares both the shifted halves and the index against a step-by-step model. A second case that falls in a single cycle is an arithmetic left step that both sets `ovf` and ends the operation. In that case the flag must already be high when `done` arrives.

// File: rtl/dw_shift_norm.sv
module dw_shift_norm #(
  parameter int W  = 24,
  parameter int CW = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         shl,
  input  logic [2:0]   subop,
  input  logic [CW-1:0] count,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] idx_in,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out,
  output logic [W-1:0] idx_out,
  output logic         done,
  output logic         illegal,
  output logic         ovf
);
  localparam int DW   = 2 * W;
  localparam int MAXC = DW;
  localparam int RW   = $clog2(MAXC + 1);

  logic [W-1:0]  hi_q, lo_q, idx_q;
  logic [RW-1:0] rem_q;
  logic          busy_q, left_q, sign_q, ovf_q, done_q, ill_q;
  logic [2:0]    op_q;

  logic [RW-1:0] sat, rem_init;
  logic          legal, norm, rot, stop;
  logic [DW-1:0] pair, nxt;

  assign sat = (count > CW'(MAXC)) ? RW'(MAXC) : RW'(count);
  assign legal = shl ? (subop[0] == 1'b0) : (subop == 3'd0 || subop == 3'd4 || subop == 3'd5);
  assign rem_init = (subop == 3'd4 && sat == RW'(MAXC)) ? '0 : sat;

  assign pair = {hi_q, lo_q};
  assign rot  = (op_q == 3'd4);
  assign norm = left_q && (op_q == 3'd2 || op_q == 3'd6);
  assign stop = (rem_q == '0) || (norm && (hi_q[W-1] ^ hi_q[W-2]));

  always_comb begin
    if (left_q)
      nxt = {pair[DW-2:0], (rot || op_q == 3'd6) ? pair[DW-1] : 1'b0};
    else
      nxt = {rot ? pair[0] : ((op_q == 3'd0) ? hi_q[W-1] : 1'b0), pair[DW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0; idx_q <= '0; rem_q <= '0; op_q <= '0;
      busy_q <= 1'b0; left_q <= 1'b0; sign_q <= 1'b0;
      ovf_q <= 1'b0; done_q <= 1'b0; ill_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      if (!busy_q && start) begin
        hi_q   <= hi_in;
        lo_q   <= lo_in;
        idx_q  <= idx_in;
        left_q <= shl;
        op_q   <= subop;
        rem_q  <= rem_init;
        sign_q <= hi_in[W-1];
        ovf_q  <= 1'b0;
        if (legal) busy_q <= 1'b1;
        else begin
          done_q <= 1'b1;
          ill_q  <= 1'b1;
        end
      end else if (busy_q) begin
        if (stop) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          {hi_q, lo_q} <= nxt;
          rem_q <= rem_q - RW'(1);
          if (norm) idx_q <= idx_q - W'(1);
          if (left_q && op_q == 3'd0 && nxt[DW-1] != sign_q) ovf_q <= 1'b1;
        end
      end
    end
  end

  assign hi_out  = hi_q;
  assign lo_out  = lo_q;
  assign idx_out = idx_q;
  assign done    = done_q;
  assign illegal = ill_q;
  assign ovf     = ovf_q;

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r8_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> done);
  a_r8_illegal_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start && !legal) |=> (illegal && done && !busy_q));
  a_r4_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !norm) |=> $stable(idx_q));
  a_r4_norm_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && norm && (hi_q[W-1] ^ hi_q[W-2])) |=> ($stable(hi_q) && $stable(lo_q) && done));
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n) rem_q <= RW'(MAXC));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !stop) |=> $stable(op_q) && $stable(left_q));
endmodule

// File: tb/dw_shift_norm_tb.sv
module dw_shift_norm_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, shl = 1'b0;
  logic [2:0] subop = '0;
  logic [8:0] count = '0;
  logic [23:0] hi_in = '0, lo_in = '0, idx_in = '0;
  logic [23:0] hi_out, lo_out, idx_out;
  logic done, illegal, ovf;
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  dw_shift_norm u_dut (.clk(clk), .rst_n(rst_n), .start(start), .shl(shl), .subop(subop),
    .count(count), .hi_in(hi_in), .lo_in(lo_in), .idx_in(idx_in), .hi_out(hi_out),
    .lo_out(lo_out), .idx_out(idx_out), .done(done), .illegal(illegal), .ovf(ovf));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [75:0] act, input logic [75:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic l, input logic [2:0] op, input logic [8:0] n,
                        input logic [23:0] h, input logic [23:0] lo, input logic [23:0] x);
    logic [47:0] p;
    logic [23:0] ex;
    logic ill, eo, s;
    int k, lim, waitc;
    string req;
    p = {h, lo}; ex = x; eo = 1'b0; s = h[23];
    ill = l ? op[0] : !(op == 3'd0 || op == 3'd4 || op == 3'd5);
    k = (n > 48) ? 48 : int'(n);
    req = (n > 48) ? "R1" : (n == 0) ? "R7" : "R2";
    if (ill) req = "R8";
    else if (!l && op == 3'd4) begin
      req = "R6";
      for (int i = 0; i < k % 48; i++) p = {p[0], p[47:1]};
    end else if (!l) begin
      for (int i = 0; i < k; i++) p = {(op == 3'd0) ? p[47] : 1'b0, p[47:1]};
    end else if (op == 3'd0) begin
      if (n != 0 && n <= 48) req = "R3";
      for (int i = 0; i < k; i++) begin
        p = {p[46:0], 1'b0};
        if (p[47] != s) eo = 1'b1;
      end
    end else if (op == 3'd4) begin
      req = "R6";
      for (int i = 0; i < k % 48; i++) p = {p[46:0], p[47]};
    end else begin
      if (n != 0 && n <= 48) req = (op == 3'd2) ? "R4" : "R5";
      lim = 0;
      for (int i = 0; i < k; i++) begin
        if (p[47] ^ p[46]) break;
        p = {p[46:0], (op == 3'd6) ? p[47] : 1'b0};
        lim++;
      end
      ex = x - 24'(lim);
    end
    @(negedge clk);
    start = 1'b1; shl = l; subop = op; count = n; hi_in = h; lo_in = lo; idx_in = x;
    @(negedge clk);
    hi_in = ~h; lo_in = ~lo; idx_in = ~x; subop = op ^ 3'd1; count = 9'd3; shl = ~l;
    waitc = 0;
    while (!done && waitc < 80) begin
      @(negedge clk);
      waitc++;
    end
    start = 1'b0;
    if (ill && waitc != 0) chk("R8 latency", 76'(waitc), 76'(0));
    chk({req, " R10 result"}, {ovf, illegal, done, hi_out, lo_out, idx_out},
        {eo, ill, 1'b1, p, ex});
    @(negedge clk);
    chk("R9 done low", {75'(0), done}, 76'(0));
  endtask

  initial begin
    logic [47:0] pats [6];
    int cnts [20];
    pats[0] = 48'h000001_800000; pats[1] = 48'h5A3C0F_123456;
    pats[2] = 48'hFFFFF0_00000F; pats[3] = 48'h000000_000000;
    pats[4] = 48'h400000_ABCDEF; pats[5] = 48'hFFFFFF_7FFFFF;
    cnts = '{0, 1, 2, 3, 5, 7, 11, 17, 22, 23, 24, 25, 31, 40, 46, 47, 48, 49, 100, 511};
    repeat (3) @(negedge clk);
    chk("R11 reset", {ovf, illegal, done, hi_out, lo_out, idx_out}, 76'(0));
    rst_n = 1'b1;
    for (int d = 0; d < 2; d++)
      for (int op = 0; op < 8; op++)
        for (int pi = 0; pi < 6; pi++)
          for (int ci = 0; ci < 20; ci++)
            run_op(d[0], op[2:0], 9'(cnts[ci]), pats[pi][47:24], pats[pi][23:0], 24'h000010);
    run_op(1'b1, 3'd2, 9'd30, 24'h000000, 24'h000000, 24'h000005);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule